// File: doc/BRIEF.md
# Sixteen-bit timer/counter with byte-wide access

This block is a 16-bit up-counter with a prescaled count enable, a compare register and a capture register, reached through an 8-bit register bus. Every 16-bit register is read and written through one shared temporary byte. A high-byte write only parks its byte there, and the following low-byte write commits both bytes in one cycle. A low-byte read returns the live low byte and, in the same cycle, copies the matching high byte into the temporary byte, where a later high-byte read finds it. Software therefore sees coherent 16-bit values even while the counter runs.

The counter can wrap freely at 0xFFFF or restart from zero at a selectable top value: either the compare register or the capture register. Two event flags record a wrap and a compare match. Each flag has a mask bit, and the request line is gated by a global enable input. An acknowledge from the interrupt controller clears the flag being serviced.

Top module: `timer16`

## Requirements
- R1: After reset the counter, compare, capture, control, mask and flag registers are zero, `irq_o` is low, and every register reads 0.
- R2: Register addresses are: 0 control, 1/2 counter low/high, 3/4 compare low/high, 5/6 capture low/high, 7 flags, 8 mask. A high-byte write changes only the temporary byte. A low-byte write loads {temporary byte, data} into the 16-bit register in one cycle, so writing low 0x22 and then high 0x55 leaves the counter at 0x0022.
- R3: A low-byte read returns the register's current low byte and copies its high byte into the temporary byte in the same cycle. A high-byte read returns the temporary byte, so a high read issued before any low read returns the stale latched value.
- R4: Counting carries across the byte boundary (0x2233 becomes 0x2234).
- R5: Control bits [2:0] select the count rate. Code 1 counts every cycle, and codes 2, 3, 4 and 5 count every 8, 64, 256 and 1024 cycles. Codes 0, 6 and 7 stop the counter. A control write restarts the divider, so with divide-by-N the first count lands N cycles after the write.
- R6: With control bit 3 clear (normal mode), the counter wraps from 0xFFFF to 0 and sets flag bit 0.
- R7: With control bits [4:3] = 01, the counter restarts at 0 on the count after it equals the compare register. Flag bit 0 is not set.
- R8: With control bits [4:3] = 11, the counter restarts at 0 on the count after it equals the capture register. Flag bit 0 is not set.
- R9: Flag bit 1 is set on every count made while the counter equals the compare register, in any mode. With mask bit 1 clear, no request follows.
- R10: Writing 1 to a flag bit clears it. A flag set in the same cycle as its clear stays set.
- R11: `irq_o` = `gie_i` AND (any flag with its mask bit set). `irq_ack_i` while `irq_o` is high clears the serviced flag, and the compare flag takes priority over the wrap flag.
- R12: A counter low-byte write made in a cycle that also carries a count loads the written value without adding the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of `rd_en_i` |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle: a hardware flag set against a software write-1-to-clear, and a count against a counter load from the bus. The bench provokes the first by issuing the flag clear exactly in the cycle where the counter wraps at divide-by-1, then reads the flag back and expects it set. It provokes the second by loading the low byte in the cycle after the counter starts, when a count is also pending. It then stops the counter one count later and expects the loaded value plus exactly one.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NSRC   = 2;
  localparam int unsigned FL_WRAP = 0;
  localparam int unsigned FL_CMP  = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 4'd0,
    REG_CNT_L = 4'd1,
    REG_CNT_H = 4'd2,
    REG_CMP_L = 4'd3,
    REG_CMP_H = 4'd4,
    REG_CAP_L = 4'd5,
    REG_CAP_H = 4'd6,
    REG_FLAG  = 4'd7,
    REG_MASK  = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/timer16_psc.sv
module timer16_psc #(
  parameter int unsigned EXP_A = 3,
  parameter int unsigned EXP_B = 6,
  parameter int unsigned EXP_C = 8,
  parameter int unsigned EXP_D = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  localparam int unsigned DIV_W = EXP_D;
  localparam logic [DIV_W-1:0] M_A = DIV_W'((1 << EXP_A) - 1);
  localparam logic [DIV_W-1:0] M_B = DIV_W'((1 << EXP_B) - 1);
  localparam logic [DIV_W-1:0] M_C = DIV_W'((1 << EXP_C) - 1);
  localparam logic [DIV_W-1:0] M_D = DIV_W'((1 << EXP_D) - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      3'd1:    tick_o = 1'b1;
      3'd2:    tick_o = (div_q & M_A) == M_A;
      3'd3:    tick_o = (div_q & M_B) == M_B;
      3'd4:    tick_o = (div_q & M_C) == M_C;
      3'd5:    tick_o = (div_q & M_D) == M_D;
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/timer16_cnt.sv
module timer16_cnt
  import timer16_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,   // [0] restart at top, [1] top is capture
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [NSRC-1:0]  clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [NSRC-1:0]  flags_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [NSRC-1:0]  flags_q, set;
  logic             adv, top_hit;

  assign adv     = tick_i & ~load_i;
  assign top_hit = cnt_q == (mode_i[1] ? cap_i : cmp_i);

  always_comb begin
    set          = '0;
    set[FL_WRAP] = adv & ~mode_i[0] & (&cnt_q);
    set[FL_CMP]  = adv & (cnt_q == cmp_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      flags_q <= '0;
    end else begin
      if (load_i)                   cnt_q <= load_val_i;
      else if (tick_i && mode_i[0] && top_hit) cnt_q <= '0;
      else if (tick_i)              cnt_q <= cnt_q + 1'b1;
      flags_q <= (flags_q & ~clr_i) | set;  // set wins
    end
  end

  assign cnt_o   = cnt_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/timer16_regs.sv
module timer16_regs
  import timer16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [NSRC-1:0]   flags_i,
  output logic [4:0]        ctrl_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic [NSRC-1:0]   mask_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [NSRC-1:0]   flag_clr_o,
  output logic              psc_clr_o
);
  logic [BYTE_W-1:0] tmp_q;
  logic [4:0]        ctrl_q;
  logic [CNT_W-1:0]  cmp_q, cap_q;
  logic [NSRC-1:0]   mask_q;
  logic              rd;

  assign rd         = rd_en_i & ~wr_en_i;
  assign load_o     = wr_en_i && addr_i == REG_CNT_L;
  assign load_val_o = {tmp_q, wdata_i};
  assign flag_clr_o = (wr_en_i && addr_i == REG_FLAG) ? wdata_i[NSRC-1:0] : '0;
  assign psc_clr_o  = wr_en_i && addr_i == REG_CTRL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_q  <= '0;
      ctrl_q <= '0;
      cmp_q  <= '0;
      cap_q  <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        REG_CTRL:  ctrl_q <= wdata_i[4:0];
        REG_CNT_H, REG_CMP_H, REG_CAP_H: tmp_q <= wdata_i;
        REG_CMP_L: cmp_q  <= {tmp_q, wdata_i};
        REG_CAP_L: cap_q  <= {tmp_q, wdata_i};
        REG_MASK:  mask_q <= wdata_i[NSRC-1:0];
        default: ;
      endcase
    end else if (rd) begin
      unique case (addr_i)
        REG_CNT_L: tmp_q <= cnt_i[CNT_W-1:BYTE_W];
        REG_CMP_L: tmp_q <= cmp_q[CNT_W-1:BYTE_W];
        REG_CAP_L: tmp_q <= cap_q[CNT_W-1:BYTE_W];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        REG_CTRL:  rdata_o = BYTE_W'(ctrl_q);
        REG_CNT_L: rdata_o = cnt_i[BYTE_W-1:0];
        REG_CMP_L: rdata_o = cmp_q[BYTE_W-1:0];
        REG_CAP_L: rdata_o = cap_q[BYTE_W-1:0];
        REG_CNT_H, REG_CMP_H, REG_CAP_H: rdata_o = tmp_q;
        REG_FLAG:  rdata_o = BYTE_W'(flags_i);
        REG_MASK:  rdata_o = BYTE_W'(mask_q);
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;
  assign cap_o  = cap_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/timer16.sv
module timer16
  import timer16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              gie_i,
  input  logic              irq_ack_i,
  output logic              irq_o
);
  logic [4:0]       ctrl;
  logic [2:0]       clk_sel;
  logic [1:0]       mode;
  logic [CNT_W-1:0] cnt, cmp, cap, cnt_wdata;
  logic [NSRC-1:0]  flags, mask, pend, bus_clr, ack_clr;
  logic             cnt_wr, psc_clr, tick;

  assign clk_sel = ctrl[2:0];
  assign mode    = ctrl[4:3];

  timer16_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .flags_i(flags), .ctrl_o(ctrl), .cmp_o(cmp), .cap_o(cap),
    .mask_o(mask), .load_o(cnt_wr), .load_val_o(cnt_wdata),
    .flag_clr_o(bus_clr), .psc_clr_o(psc_clr)
  );

  timer16_psc u_psc (
    .clk_i, .rst_ni, .clr_i(psc_clr), .sel_i(clk_sel), .tick_o(tick)
  );

  timer16_cnt u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .mode_i(mode), .cmp_i(cmp), .cap_i(cap),
    .load_i(cnt_wr), .load_val_i(cnt_wdata), .clr_i(bus_clr | ack_clr),
    .cnt_o(cnt), .flags_o(flags)
  );

  assign pend  = flags & mask;
  assign irq_o = gie_i & (|pend);

  // compare outranks wrap when the request is serviced
  always_comb begin
    ack_clr = '0;
    if (irq_ack_i && irq_o) begin
      if (pend[FL_CMP]) ack_clr[FL_CMP]  = 1'b1;
      else              ack_clr[FL_WRAP] = 1'b1;
    end
  end
endmodule

// File: rtl/timer16_chk.sv
module timer16_chk
  import timer16_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gie_i,
  input logic             irq_o,
  input logic [2:0]       clk_sel,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             tick,
  input logic [CNT_W-1:0] cmp,
  input logic [CNT_W-1:0] cap,
  input logic [NSRC-1:0]  flags
);
  // R11
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);

  // R12
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt == $past(cnt_wdata));

  // R5
  stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel == 3'd0 && !cnt_wr) |=> $stable(cnt));

  // R7
  cmp_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b01 && tick && !cnt_wr && cnt == cmp) |=> cnt == '0);

  // R8
  cap_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b11 && tick && !cnt_wr && cnt == cap) |=> cnt == '0);

  // R7
  no_wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode[0] |=> !$rose(flags[FL_WRAP]));
endmodule

bind timer16 timer16_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gie_i(gie_i), .irq_o(irq_o),
  .clk_sel(clk_sel), .mode(mode), .cnt(cnt), .cnt_wr(cnt_wr),
  .cnt_wdata(cnt_wdata), .tick(tick), .cmp(cmp), .cap(cap), .flags(flags)
);

// File: tb/tb_timer16.sv
`timescale 1ns/1ps
module tb_timer16;
  localparam logic [3:0] A_CTRL = 4'd0, A_CNT_L = 4'd1, A_CNT_H = 4'd2,
                         A_CMP_L = 4'd3, A_CMP_H = 4'd4, A_CAP_L = 4'd5,
                         A_CAP_H = 4'd6, A_FLAG = 4'd7, A_MASK = 4'd8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, gie = 1'b0, ack = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  timer16 dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .gie_i(gie), .irq_ack_i(ack), .irq_o(irq)
  );

  // monitor: compare each read against the expected item queued by the driver
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read got %h", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s got %h exp %h", t, rdata, e);
        end
      end
    end
  end

  // every op starts 1 ns after a rising edge and takes effect at the next one
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq got %b exp %b", t, irq, e);
    end
  endtask

  task automatic load16(input logic [3:0] lo, input logic [15:0] v);
    wr(lo + 4'd1, v[15:8]);
    wr(lo, v[7:0]);
  endtask

  // exactly n counts at divide-by-1
  task automatic run(input logic [1:0] md, input int n);
    wr(A_CTRL, {3'b000, md, 3'b001});
    idle(n - 1);
    wr(A_CTRL, {3'b000, md, 3'b000});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(A_CNT_L, 8'h00, "R1 cnt lo");
    rd(A_CNT_H, 8'h00, "R1 cnt hi");
    rd(A_FLAG,  8'h00, "R1 flags");
    rd(A_CTRL,  8'h00, "R1 ctrl");

    // R2 low then high: high only parks in the latch
    wr(A_CNT_L, 8'h22);
    wr(A_CNT_H, 8'h55);
    rd(A_CNT_L, 8'h22, "R2 low kept");
    rd(A_CNT_H, 8'h00, "R2 high not applied");

    // R4 carry across bytes
    load16(A_CNT_L, 16'h2233);
    run(2'b00, 1);
    rd(A_CNT_L, 8'h34, "R4 lo");
    rd(A_CNT_H, 8'h22, "R4 hi");

    // R3 high read before low returns stale latch
    load16(A_CNT_L, 16'h00FF);
    run(2'b00, 1);
    rd(A_CNT_H, 8'h00, "R3 stale hi");
    rd(A_CNT_L, 8'h00, "R3 lo");
    rd(A_CNT_H, 8'h01, "R3 snap hi");

    // R6 wrap sets flag bit 0
    load16(A_CNT_L, 16'hFFFF);
    run(2'b00, 1);
    rd(A_CNT_L, 8'h00, "R6 lo");
    rd(A_CNT_H, 8'h00, "R6 hi");
    rd(A_FLAG,  8'h01, "R6 flag");

    // R10 write one to clear
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, 8'h00, "R10 cleared");

    // R11 request gated by mask and enable, cleared by acknowledge
    wr(A_MASK, 8'h01);
    gie = 1'b1;
    load16(A_CNT_L, 16'hFFFF);
    run(2'b00, 1);
    chk_irq(1'b1, "R11 raised");
    gie = 1'b0;
    step();
    chk_irq(1'b0, "R11 gie off");
    gie = 1'b1;
    step();
    chk_irq(1'b1, "R11 gie on");
    do_ack();
    chk_irq(1'b0, "R11 after ack");
    rd(A_FLAG, 8'h00, "R11 ack cleared");

    // R9 compare flag without request when masked
    load16(A_CMP_L, 16'h0010);
    load16(A_CNT_L, 16'h0010);
    run(2'b00, 1);
    rd(A_FLAG, 8'h02, "R9 cmp flag");
    chk_irq(1'b0, "R9 masked");
    wr(A_MASK, 8'h03);
    step();
    chk_irq(1'b1, "R11 cmp unmasked");
    load16(A_CNT_L, 16'hFFFF);
    run(2'b00, 1);
    rd(A_FLAG, 8'h03, "R11 both pending");
    do_ack();
    rd(A_FLAG, 8'h01, "R11 cmp first");
    do_ack();
    rd(A_FLAG, 8'h00, "R11 wrap second");
    wr(A_MASK, 8'h00);
    gie = 1'b0;

    // R7 compare as top: 3,4,5,0,1
    load16(A_CMP_L, 16'h0005);
    load16(A_CNT_L, 16'h0003);
    run(2'b01, 4);
    rd(A_CNT_L, 8'h01, "R7 restart");
    rd(A_FLAG, 8'h02, "R7 no wrap flag");
    wr(A_FLAG, 8'h03);

    // R8 capture as top: F,10,0,1
    load16(A_CAP_L, 16'h0010);
    load16(A_CNT_L, 16'h000F);
    run(2'b11, 3);
    rd(A_CNT_L, 8'h01, "R8 restart");
    rd(A_FLAG, 8'h00, "R8 no flags");
    rd(A_CAP_L, 8'h10, "R8 cap lo");
    rd(A_CAP_H, 8'h00, "R8 cap hi");

    // R5 prescaler: divide-by-8, divide-by-64, stop codes
    load16(A_CNT_L, 16'h0000);
    wr(A_CTRL, 8'h02);
    idle(15);
    rd(A_CNT_L, 8'h01, "R5 div8 first");
    rd(A_CNT_L, 8'h02, "R5 div8 second");
    wr(A_CTRL, 8'h03);
    idle(63);
    rd(A_CNT_L, 8'h02, "R5 div64 before");
    rd(A_CNT_L, 8'h03, "R5 div64 after");
    wr(A_CTRL, 8'h06);
    idle(100);
    rd(A_CNT_L, 8'h03, "R5 code6 stopped");
    wr(A_CTRL, 8'h00);

    // R12 load in a counting cycle takes the written value only
    wr(A_CNT_H, 8'h12);
    wr(A_CTRL, 8'h01);
    wr(A_CNT_L, 8'h34);
    wr(A_CTRL, 8'h00);
    rd(A_CNT_L, 8'h35, "R12 lo");
    rd(A_CNT_H, 8'h12, "R12 hi");

    // R10 set and clear in the same cycle: set wins
    load16(A_CNT_L, 16'hFFFF);
    wr(A_CTRL, 8'h01);
    wr(A_FLAG, 8'h01);
    wr(A_CTRL, 8'h00);
    rd(A_FLAG, 8'h01, "R10 set beats clear");

    step();
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard left %0d exp 0", exp_q.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule